// File: doc/BRIEF.md
# NiMH Charge Phase Controller

This block sequences a nickel battery charger through its phases: a one-cycle pending evaluation, continuous fast charge, an optional reduced-rate top-off and an untimed maintenance trickle. A low-power state is also provided. Analog comparison is done elsewhere. The block receives one-bit flags for the cell voltage (above maximum, below minimum, above power-down level), for temperature (high-fault region, cutoff), and for a drop-based end-of-charge decision. It also receives a two-bit rate select, an inhibit input and a one-millisecond tick.

It owns a safety timer that limits fast charge and, when top-off is enabled, limits top-off again with the same value. It also owns a pulse modulator that produces the duty-cycled current for top-off and trickle. The charge-enable output is active high: 1 means current may flow. The LED output is 1 when the status LED is pulled low and 0 when that pin is released. All durations are parameters counted in ticks.

Top module: `chg_phase_ctrl`

## Requirements
- R1: A charge cycle starts after reset, and also in the cycle after `cell_over_max` falls from 1 to 0. The pending state lasts one clock and then picks the next phase.
- R2: In the pending state, fast charge is entered only if `cell_over_max`, `cell_under_min` and `temp_hot_fault` are all 0. Otherwise the block enters trickle and stays there until a new cycle starts.
- R3: During fast charge or top-off, `cell_over_max` or `temp_cutoff` moves the block to trickle on the next clock. This holds even while `inhibit` is 1.
- R4: Fast charge ends after LIMIT uninhibited ticks, where LIMIT = TMO_MID_MIN, TMO_LOW_MIN or TMO_HIGH_MIN times MS_PER_MIN for the mid, low or high rate. When `inhibit` is 0, a `drop_term` pulse ends fast charge earlier.
- R5: When fast charge ends by timer or by `drop_term`, the block enters top-off only at the mid rate. At the other rates it enters trickle.
- R6: In top-off, `chg_en` is 1 while the pulse phase is below TOPOFF_ON. `drop_term` has no effect in top-off. Top-off ends in trickle after LIMIT further ticks, because the timer restarts from zero when the phase changes.
- R7: The pulse phase equals the number of ticks since reset, modulo PULSE_PERIOD. In trickle, `chg_en` is 1 while the phase is below TRK_ON_MID, TRK_ON_LOW or TRK_ON_HIGH for the selected rate. Trickle has no time limit.
- R8: `led_on` is 1 only in fast charge.
- R9: While `inhibit` is 1, the phase, the safety timer and `led_on` are frozen, and `chg_en` follows the trickle pulses. When `inhibit` falls, charging resumes with the elapsed time kept.
- R10: While `cell_over_pd` is 1, both outputs are 0 from the next clock on. After it returns to 0, the block enters trickle.
- R11: `mode_sel` encodes 0 as low rate, 1 as mid rate and 2 as high rate. The value 3 behaves as the mid rate.
- R12: In fast charge with `inhibit` at 0, `chg_en` is held at 1 continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cell_over_max | input | 1 | Cell voltage above maximum |
| cell_under_min | input | 1 | Cell voltage below minimum |
| cell_over_pd | input | 1 | Cell voltage above power-down level |
| temp_hot_fault | input | 1 | Temperature in high-fault region |
| temp_cutoff | input | 1 | Temperature past cutoff |
| drop_term | input | 1 | Voltage-drop termination from detector |
| mode_sel | input | 2 | Rate select: 0 low, 1 mid, 2 high, 3 mid |
| inhibit | input | 1 | Suspend fast charge and top-off |
| chg_en | output | 1 | Charge current enable, active high |
| led_on | output | 1 | Status LED pulled low when 1 |

## Verification
The bench sets MS_PER_MIN to 1, so the 160, 80 and 40 minute limits become that many ticks. It also uses a pulse period of 16 ticks, a top-off width of 4 and trickle widths of 6, 3 and 1. With these values every safety limit can be run to its exact end, and a complete sweep through top-off is practical. Every pulse phase is compared against a count the bench keeps itself. Because the top-off width differs from the mid trickle width, the bench can tell top-off and trickle apart at the outputs alone.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    PH_PEND    = 3'd0,
    PH_FAST    = 3'd1,
    PH_TOPOFF  = 3'd2,
    PH_TRICKLE = 3'd3,
    PH_LOWPWR  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    RATE_LOW  = 2'd0,
    RATE_MID  = 2'd1,
    RATE_HIGH = 2'd2
  } rate_e;

  // R11: code 3 folds onto the mid rate
  function automatic rate_e decode_rate(input logic [1:0] sel);
    case (sel)
      2'd0:    return RATE_LOW;
      2'd2:    return RATE_HIGH;
      default: return RATE_MID;
    endcase
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/chg_safety_timer.sv
module chg_safety_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (step && cnt_q < limit) cnt_q <= cnt_q + 1'b1;
  end

  assign done = (cnt_q >= limit);

  AST_DONE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr && $stable(limit)) |=> done); // R4
endmodule

// File: rtl/chg_pulse_mod.sv
module chg_pulse_mod #(
  parameter int PERIOD = 1170,
  parameter int PH_W   = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] on_width,
  output logic            pulse_on
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
  end

  assign pulse_on = (phase_q < on_width);

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST); // R7
endmodule

// File: rtl/chg_phase_ctrl.sv
module chg_phase_ctrl #(
  parameter int MS_PER_MIN   = 60000,
  parameter int TMO_MID_MIN  = 160,
  parameter int TMO_LOW_MIN  = 80,
  parameter int TMO_HIGH_MIN = 40,
  parameter int PULSE_PERIOD = 1170,
  parameter int TOPOFF_ON    = 73,
  parameter int TRK_ON_MID   = 73,
  parameter int TRK_ON_LOW   = 37,
  parameter int TRK_ON_HIGH  = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       cell_over_max,
  input  logic       cell_under_min,
  input  logic       cell_over_pd,
  input  logic       temp_hot_fault,
  input  logic       temp_cutoff,
  input  logic       drop_term,
  input  logic [1:0] mode_sel,
  input  logic       inhibit,
  output logic       chg_en,
  output logic       led_on
);
  import chg_pkg::*;

  localparam int TMO_MAX = max3(TMO_MID_MIN, TMO_LOW_MIN, TMO_HIGH_MIN) * MS_PER_MIN;
  localparam int CNT_W   = $clog2(TMO_MAX + 1);
  localparam int PH_W    = $clog2(PULSE_PERIOD + 1);

  phase_e st_q, st_d;
  rate_e  rate;
  logic   max_prev_q;
  logic   max_fell, start_ok, hard_stop, in_fast, in_topoff;
  logic   tmr_clr, tmr_step, tmr_done, pulse_on;
  logic [CNT_W-1:0] tmr_limit;
  logic [PH_W-1:0]  on_width, trk_width;

  assign rate      = decode_rate(mode_sel);
  assign max_fell  = max_prev_q & ~cell_over_max;
  assign start_ok  = ~cell_over_max & ~cell_under_min & ~temp_hot_fault;
  assign hard_stop = cell_over_max | temp_cutoff;
  assign in_fast   = (st_q == PH_FAST);
  assign in_topoff = (st_q == PH_TOPOFF);

  always_comb begin
    case (rate)
      RATE_LOW:  begin tmr_limit = CNT_W'(TMO_LOW_MIN * MS_PER_MIN);  trk_width = PH_W'(TRK_ON_LOW);  end
      RATE_HIGH: begin tmr_limit = CNT_W'(TMO_HIGH_MIN * MS_PER_MIN); trk_width = PH_W'(TRK_ON_HIGH); end
      default:   begin tmr_limit = CNT_W'(TMO_MID_MIN * MS_PER_MIN);  trk_width = PH_W'(TRK_ON_MID);  end
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (cell_over_pd) begin
      st_d = PH_LOWPWR;
    end else if (st_q == PH_LOWPWR) begin
      st_d = PH_TRICKLE;
    end else if (max_fell) begin
      st_d = PH_PEND;
    end else begin
      case (st_q)
        PH_PEND: st_d = start_ok ? PH_FAST : PH_TRICKLE;
        PH_FAST: begin
          if (hard_stop) st_d = PH_TRICKLE;
          else if (!inhibit && (tmr_done || drop_term))
            st_d = (rate == RATE_MID) ? PH_TOPOFF : PH_TRICKLE;
        end
        PH_TOPOFF: begin
          if (hard_stop || (!inhibit && tmr_done)) st_d = PH_TRICKLE;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= PH_PEND;
      max_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      max_prev_q <= cell_over_max;
    end
  end

  assign tmr_clr  = (st_d != st_q);
  assign tmr_step = ms_tick & ~inhibit & (in_fast | in_topoff);

  chg_safety_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .step(tmr_step),
    .limit(tmr_limit), .done(tmr_done)
  );

  assign on_width = (in_topoff && !inhibit) ? PH_W'(TOPOFF_ON) : trk_width;

  chg_pulse_mod #(.PERIOD(PULSE_PERIOD), .PH_W(PH_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .on_width(on_width), .pulse_on(pulse_on)
  );

  always_comb begin
    case (st_q)
      PH_FAST:               chg_en = ~inhibit | pulse_on;
      PH_TOPOFF, PH_TRICKLE: chg_en = pulse_on;
      default:               chg_en = 1'b0;
    endcase
  end
  assign led_on = in_fast;

  AST_LED_WITH_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (led_on && !inhibit) |-> chg_en); // R12
  AST_QUIET_POWERDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    cell_over_pd |=> (!chg_en && !led_on)); // R10
  AST_HARD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_stop && !cell_over_pd && (in_fast || in_topoff)) |=> (!in_fast && !in_topoff)); // R3
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && in_fast && !hard_stop && !cell_over_pd && !max_fell) |=> in_fast); // R9
  AST_TOPOFF_MID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_topoff) |-> $past(rate == RATE_MID)); // R5
endmodule

// File: tb/sim_chg_phase_ctrl.sv
module sim_chg_phase_ctrl;
  localparam int CLK_P = 10;
  localparam int P     = 16;
  localparam int TOPW  = 4;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
  logic cell_over_max = 0, cell_under_min = 0, cell_over_pd = 0;
  logic temp_hot_fault = 0, temp_cutoff = 0, drop_term = 0, inhibit = 0;
  logic [1:0] mode_sel = 2'd1;
  logic chg_en, led_on;

  int total = 0, bad = 0, nticks = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  chg_phase_ctrl #(
    .MS_PER_MIN(1), .PULSE_PERIOD(P), .TOPOFF_ON(TOPW),
    .TRK_ON_MID(6), .TRK_ON_LOW(3), .TRK_ON_HIGH(1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cell_over_max(cell_over_max),
    .cell_under_min(cell_under_min), .cell_over_pd(cell_over_pd),
    .temp_hot_fault(temp_hot_fault), .temp_cutoff(temp_cutoff), .drop_term(drop_term),
    .mode_sel(mode_sel), .inhibit(inhibit), .chg_en(chg_en), .led_on(led_on)
  );

  // kinds: 0 fast, 1 top-off, 2 trickle, 3 off, 4 fast under inhibit
  function automatic int trk_w(input logic [1:0] m);
    return (m == 2'd0) ? 3 : (m == 2'd2) ? 1 : 6;
  endfunction
  function automatic int limit_of(input logic [1:0] m);
    return (m == 2'd0) ? 80 : (m == 2'd2) ? 40 : 160;
  endfunction
  function automatic logic exp_en(input int kind, input int k, input logic [1:0] m);
    int ph;
    ph = k % P;
    case (kind)
      0:       return 1'b1;
      1:       return ph < TOPW;
      2, 4:    return ph < trk_w(m);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0d exp %0d (tick %0d)", tag, act, exp, nticks);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    nticks = 0;
    rst_n = 1;
    settle();
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1;
    @(negedge clk) ms_tick = 0;
    @(negedge clk);
    nticks++;
  endtask

  task automatic run_chk(input int n, input int kind, input string tag);
    for (int i = 0; i < n; i++) begin
      tick();
      check(chg_en, exp_en(kind, nticks, mode_sel), {tag, " chg_en"});
      check(led_on, (kind == 0 || kind == 4), {tag, " led_on"});
    end
  endtask

  task automatic pulse_drop();
    @(negedge clk) drop_term = 1;
    @(negedge clk) drop_term = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got 1 exp 0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 R4 R5 R6 R7 R8 R11 R12: full sweep per mode code
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m);
      do_reset();
      check(led_on, 1'b1, "R1 R8 led after reset");
      check(chg_en, 1'b1, "R12 chg_en in fast");
      run_chk(limit_of(mode_sel) - 1, 0, "R4 fast holds");
      if (mode_sel == 2'd0 || mode_sel == 2'd2) begin
        run_chk(2 * P + 1, 2, "R5 R7 trickle after fast");
      end else begin
        run_chk(limit_of(mode_sel), 1, "R6 R11 top-off window");
        run_chk(2 * P + 1, 2, "R6 R7 trickle after top-off");
      end
    end

    // R2: start qualification
    mode_sel = 2'd0;
    cell_under_min = 1; do_reset(); run_chk(P, 2, "R2 under min"); cell_under_min = 0;
    temp_hot_fault = 1; do_reset(); run_chk(P, 2, "R2 hot fault"); temp_hot_fault = 0;
    cell_over_max = 1;  do_reset(); run_chk(P, 2, "R2 over max");
    cell_over_max = 0;  settle();
    check(led_on, 1'b1, "R1 new battery restarts");

    // R4: drop ends fast at high rate
    mode_sel = 2'd2; do_reset(); run_chk(5, 0, "R4 fast pre-drop");
    pulse_drop(); run_chk(P, 2, "R4 drop to trickle");

    // R5 R6: drop at mid -> top-off, drop ignored in top-off, R3 cutoff ends it
    mode_sel = 2'd1; do_reset(); run_chk(3, 0, "R5 fast pre-drop");
    pulse_drop(); run_chk(P, 1, "R5 drop to top-off");
    pulse_drop(); run_chk(P, 1, "R6 drop ignored in top-off");
    @(negedge clk) temp_cutoff = 1; @(negedge clk) temp_cutoff = 0; @(negedge clk);
    run_chk(P, 2, "R3 cutoff ends top-off");

    // R3: over-max ends fast even under inhibit; R1 fall restarts
    do_reset(); inhibit = 1; cell_over_max = 1; settle();
    check(led_on, 1'b0, "R3 over max under inhibit");
    cell_over_max = 0; settle();
    check(led_on, 1'b1, "R1 restart after over max fall");
    inhibit = 0; settle();
    check(chg_en, 1'b1, "R12 resume fast");

    // R9: inhibit freezes timer, trickle pulses continue
    mode_sel = 2'd0; do_reset(); run_chk(30, 0, "R9 fast before inhibit");
    inhibit = 1; run_chk(100, 4, "R9 inhibited fast");
    pulse_drop(); run_chk(2, 4, "R9 drop ignored while inhibited");
    inhibit = 0; run_chk(49, 0, "R9 resumed fast");
    run_chk(P, 2, "R9 limit reached after resume");

    // R10: low power
    mode_sel = 2'd2; do_reset();
    cell_over_pd = 1; cell_over_max = 1; settle();
    run_chk(P, 3, "R10 quiet in power-down");
    cell_over_pd = 0; settle();
    run_chk(P, 2, "R10 trickle after power-down");
    cell_over_max = 0; settle();
    check(led_on, 1'b1, "R1 R10 new cycle after power-down");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule